// File: doc/BRIEF.md
# Two-Register Write Decoder on an I2C Target

This block is an I2C target that accepts write transactions only. It watches SCL and SDA through synchronizers on a system clock and finds START, repeated START and STOP conditions. It then shifts in an address byte. If the seven address bits equal the `DEV_ADDR` parameter and the direction bit is 0, the block acknowledges by holding SDA low for the ninth clock.

Each data byte that follows is acknowledged. The top bit of the byte picks where it goes. A byte with bit 7 set lands in the setup register. That register holds a 3-bit reference selection in bits 6:4, a clock-source flag in bit 3 (1 means external) and a polarity flag in bit 2 (1 means bipolar). Bit 1 of a setup byte is active low: writing it as 0 returns the configuration register to its default. Bit 0 is ignored. A byte with bit 7 clear is stored whole as the configuration register.

Any number of bytes may follow the address, in any order, and the last one written wins. A transaction ends at STOP or at a repeated START. Both registers drive parallel outputs, and each register has a one-cycle strobe that marks an update. The SDA pad is meant to be open-drain: `sda_oe` high pulls the line low.

Top module: `i2cw_target`

## Requirements
- R1: After a START, an address byte whose bits 7:1 equal DEV_ADDR and whose bit 0 is 0 is acknowledged. The block holds SDA low through the high phase of the ninth SCL clock.
- R2: After an address byte that differs from DEV_ADDR, or that has bit 0 = 1, SDA stays released. All following bits are ignored until the next START, so no register changes.
- R3: An accepted data byte with bit 7 = 1 sets ref_sel to bits 6:4, ext_clk to bit 3 and bipolar to bit 2. Bit 0 has no effect.
- R4: An accepted data byte with bit 7 = 0 loads cfg_q with the full byte.
- R5: A setup byte with bit 1 = 0 returns cfg_q to CFG_DEFAULT and still stores its own fields. A setup byte with bit 1 = 1 leaves cfg_q unchanged.
- R6: Every data byte after an acknowledged address is acknowledged on its ninth clock. Bytes may come in any order and in any number, and the last write to each register wins.
- R7: Reset sets ref_sel = 0, ext_clk = 0, bipolar = 0, cfg_q = CFG_DEFAULT and sda_oe = 0.
- R8: A STOP ends the transaction, and bits clocked after it without a new START are ignored. A repeated START immediately begins a new address phase.
- R9: setup_wr pulses for exactly one cycle per accepted setup byte. cfg_wr pulses for exactly one cycle per configuration byte and per clearing setup byte.
- R10: sda_oe is asserted only during an acknowledge clock. It rises only after an SCL falling edge, and it is never high while the master is driving data bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL line as seen at the pad |
| sda_i | input | 1 | SDA line as seen at the pad |
| sda_oe | output | 1 | 1 pulls SDA low (acknowledge) |
| ref_sel | output | 3 | Setup register: reference selection |
| ext_clk | output | 1 | Setup register: 1 = external clock source |
| bipolar | output | 1 | Setup register: 1 = bipolar, 0 = unipolar |
| cfg_q | output | 8 | Configuration register |
| setup_wr | output | 1 | One-cycle strobe on setup register update |
| cfg_wr | output | 1 | One-cycle strobe on configuration register update |

## Verification
A wrong transfer state or bit count shows on the bus first. The acknowledge lands on the wrong clock, or it goes missing, and this is visible in the ninth clock of the byte where the state went wrong. A misclassified byte or a missed clear does not show on SDA at all. It shows only on ref_sel, ext_clk, bipolar and cfg_q, and in the strobe counts, from a few system cycles after that byte's eighth bit. For that reason the register outputs are compared against a bench model after every transaction, not only at the end of the run.

// File: rtl/i2cw_pkg.sv
package i2cw_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_DATA,
    ST_DATA_ACK,
    ST_SKIP
  } xfer_state_t;

  // address byte addresses this target for a write
  function automatic logic addr_hit(input logic [7:0] b, input logic [6:0] dev);
    return (b[7:1] == dev) && !b[0];
  endfunction

  // top bit selects the setup register
  function automatic logic is_setup_byte(input logic [7:0] b);
    return b[7];
  endfunction

  // setup byte whose active-low bit 1 requests a configuration clear
  function automatic logic clears_cfg(input logic [7:0] b);
    return b[7] && !b[1];
  endfunction

endpackage

// File: rtl/i2cw_bus_cond.sv
module i2cw_bus_cond #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [LAST:0] scl_sh, sda_sh;
  logic          scl_p, sda_p, scl_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_p  <= 1'b1;
      sda_p  <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[LAST-1:0], scl_i};
      sda_sh <= {sda_sh[LAST-1:0], sda_i};
      scl_p  <= scl_sh[LAST];
      sda_p  <= sda_sh[LAST];
    end
  end

  assign scl_s     = scl_sh[LAST];
  assign sda_s     = sda_sh[LAST];
  assign scl_rise  = scl_s & ~scl_p;
  assign scl_fall  = ~scl_s & scl_p;
  assign start_det = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;

endmodule

// File: rtl/i2cw_byte_engine.sv
module i2cw_byte_engine
  import i2cw_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h35,
  parameter int         BYTE_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  output logic              sda_oe,
  output logic              byte_stb,
  output logic [BYTE_W-1:0] byte_q
);
  localparam int              CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);

  xfer_state_t       state;
  logic [CNT_W-1:0]  cnt;
  logic [BYTE_W-1:0] shreg;
  logic              shifting, byte_full, in_ack;

  assign shifting  = (state == ST_ADDR) || (state == ST_DATA);
  assign byte_full = (cnt == FULL);
  assign in_ack    = (state == ST_ADDR_ACK) || (state == ST_DATA_ACK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      shreg    <= '0;
      sda_oe   <= 1'b0;
      byte_stb <= 1'b0;
      byte_q   <= '0;
    end else begin
      byte_stb <= 1'b0;
      if (start_det) begin
        state  <= ST_ADDR;
        cnt    <= '0;
        sda_oe <= 1'b0;
      end else if (stop_det) begin
        state  <= ST_IDLE;
        sda_oe <= 1'b0;
      end else if (shifting) begin
        if (scl_rise && !byte_full) begin
          shreg <= {shreg[BYTE_W-2:0], sda_s};
          cnt   <= cnt + 1'b1;
        end else if (scl_fall && byte_full) begin
          if (state == ST_ADDR) begin
            if (addr_hit(shreg, DEV_ADDR)) begin
              state  <= ST_ADDR_ACK;
              sda_oe <= 1'b1;
            end else begin
              state <= ST_SKIP;
            end
          end else begin
            state    <= ST_DATA_ACK;
            sda_oe   <= 1'b1;
            byte_stb <= 1'b1;
            byte_q   <= shreg;
          end
        end
      end else if (in_ack && scl_fall) begin
        sda_oe <= 1'b0;
        cnt    <= '0;
        state  <= ST_DATA;
      end
    end
  end

  // R10
  ack_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sda_oe |-> in_ack);
  // R10
  oe_after_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> $past(scl_fall));
  // R2
  skip_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SKIP) |-> (!sda_oe && !byte_stb));
  // R6
  stb_with_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_stb |-> sda_oe);

endmodule

// File: rtl/i2cw_reg_bank.sv
module i2cw_reg_bank
  import i2cw_pkg::*;
#(
  parameter logic [7:0] CFG_DEFAULT = 8'h61
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       byte_stb,
  input  logic [7:0] byte_q,
  output logic [2:0] ref_sel,
  output logic       ext_clk,
  output logic       bipolar,
  output logic [7:0] cfg_q,
  output logic       setup_wr,
  output logic       cfg_wr
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_sel  <= '0;
      ext_clk  <= 1'b0;
      bipolar  <= 1'b0;
      cfg_q    <= CFG_DEFAULT;
      setup_wr <= 1'b0;
      cfg_wr   <= 1'b0;
    end else begin
      setup_wr <= 1'b0;
      cfg_wr   <= 1'b0;
      if (byte_stb) begin
        if (is_setup_byte(byte_q)) begin
          ref_sel  <= byte_q[6:4];
          ext_clk  <= byte_q[3];
          bipolar  <= byte_q[2];
          setup_wr <= 1'b1;
          if (clears_cfg(byte_q)) begin
            cfg_q  <= CFG_DEFAULT;
            cfg_wr <= 1'b1;
          end
        end else begin
          cfg_q  <= byte_q;
          cfg_wr <= 1'b1;
        end
      end
    end
  end

  // R9
  setup_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    setup_wr |=> !setup_wr);
  // R9
  cfg_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> !cfg_wr);
  // R3
  setup_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !setup_wr |-> $stable({ref_sel, ext_clk, bipolar}));
  // R4
  cfg_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_stb && !byte_q[7]) |=> (cfg_q == $past(byte_q)));
  // R5
  cfg_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_stb && byte_q[7] && !byte_q[1]) |=> (cfg_q == CFG_DEFAULT));
  // R5
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_wr |-> $stable(cfg_q));

endmodule

// File: rtl/i2cw_target.sv
module i2cw_target #(
  parameter logic [6:0] DEV_ADDR    = 7'h35,
  parameter logic [7:0] CFG_DEFAULT = 8'h61,
  parameter int         SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  output logic [2:0] ref_sel,
  output logic       ext_clk,
  output logic       bipolar,
  output logic [7:0] cfg_q,
  output logic       setup_wr,
  output logic       cfg_wr
);
  localparam int BYTE_W = 8;

  logic              sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic              byte_stb;
  logic [BYTE_W-1:0] byte_q;

  i2cw_bus_cond #(.SYNC_STAGES(SYNC_STAGES)) u_cond (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2cw_byte_engine #(.DEV_ADDR(DEV_ADDR), .BYTE_W(BYTE_W)) u_eng (
    .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
    .sda_oe(sda_oe), .byte_stb(byte_stb), .byte_q(byte_q)
  );

  i2cw_reg_bank #(.CFG_DEFAULT(CFG_DEFAULT)) u_regs (
    .clk(clk), .rst_n(rst_n), .byte_stb(byte_stb), .byte_q(byte_q),
    .ref_sel(ref_sel), .ext_clk(ext_clk), .bipolar(bipolar),
    .cfg_q(cfg_q), .setup_wr(setup_wr), .cfg_wr(cfg_wr)
  );

  // R8
  stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_oe);

endmodule

// File: tb/i2cw_target_bench.sv
module i2cw_target_bench;
  localparam logic [6:0] DEV = 7'h35;
  localparam logic [7:0] CDEF = 8'h61;
  localparam int H = 10;
  localparam int NV = 10;
  // {ack, addr[6:0], rw, nbytes[1:0], b0, b1}
  localparam logic [26:0] VEC [NV] = '{
    {1'b1, 7'h35, 1'b0, 2'd1, 8'hD6, 8'h00},
    {1'b1, 7'h35, 1'b0, 2'd1, 8'h2B, 8'h00},
    {1'b1, 7'h35, 1'b0, 2'd2, 8'hAB, 8'h11},
    {1'b1, 7'h35, 1'b0, 2'd2, 8'h7E, 8'hF5},
    {1'b1, 7'h35, 1'b0, 2'd2, 8'h40, 8'h88},
    {1'b0, 7'h36, 1'b0, 2'd2, 8'hFE, 8'h33},
    {1'b0, 7'h35, 1'b1, 2'd1, 8'h12, 8'h00},
    {1'b1, 7'h35, 1'b0, 2'd2, 8'h05, 8'h06},
    {1'b1, 7'h35, 1'b0, 2'd2, 8'h97, 8'hCB},
    {1'b1, 7'h35, 1'b0, 2'd1, 8'h00, 8'h00}
  };

  logic clk = 1'b0, rst_n = 1'b0, scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe, ext_clk, bipolar, setup_wr, cfg_wr, sda_line;
  logic [2:0] ref_sel;
  logic [7:0] cfg_q;
  int checks = 0, failures = 0, n_setup = 0, n_cfg = 0;
  logic oe_bad = 1'b0;
  logic [2:0] m_ref = '0;
  logic m_ext = 1'b0, m_bip = 1'b0;
  logic [7:0] m_cfg = CDEF;
  int e_setup = 0, e_cfg = 0;

  always #4 clk = ~clk;
  assign sda_line = sda_m & ~sda_oe;

  i2cw_target #(.DEV_ADDR(DEV), .CFG_DEFAULT(CDEF)) u_i2cw_target (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_oe(sda_oe), .ref_sel(ref_sel), .ext_clk(ext_clk),
    .bipolar(bipolar), .cfg_q(cfg_q), .setup_wr(setup_wr), .cfg_wr(cfg_wr)
  );

  always @(negedge clk) begin
    if (setup_wr) n_setup++;
    if (cfg_wr) n_cfg++;
  end

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic i2c_start();
    sda_m = 1'b1; wt(H); scl_m = 1'b1; wt(H); sda_m = 1'b0; wt(H); scl_m = 1'b0; wt(H);
  endtask

  task automatic i2c_stop();
    sda_m = 1'b0; wt(H); scl_m = 1'b1; wt(H); sda_m = 1'b1; wt(H);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wt(H); scl_m = 1'b1; wt(H / 2);
      if (sda_oe) oe_bad = 1'b1;
      wt(H / 2); scl_m = 1'b0; wt(H);
    end
    sda_m = 1'b1; wt(H); scl_m = 1'b1; wt(H / 2);
    ack = ~sda_line;
    wt(H / 2); scl_m = 1'b0; wt(H);
  endtask

  // bench model of the register update rules (R3, R4, R5)
  task automatic model_byte(input logic [7:0] b);
    if (b[7]) begin
      m_ref = b[6:4]; m_ext = b[3]; m_bip = b[2]; e_setup++;
      if (!b[1]) begin m_cfg = CDEF; e_cfg++; end
    end else begin
      m_cfg = b; e_cfg++;
    end
  endtask

  task automatic check_regs(input string req);
    check({ref_sel, ext_clk, bipolar, cfg_q} == {m_ref, m_ext, m_bip, m_cfg}, req,
          {ref_sel, ext_clk, bipolar, cfg_q}, {m_ref, m_ext, m_bip, m_cfg});
  endtask

  initial begin
    wt(200000);
    failures++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic ack;
    logic [26:0] v;
    wt(5);
    rst_n = 1'b1;
    wt(5);
    // R7 reset state
    check({ref_sel, ext_clk, bipolar, cfg_q, sda_oe} == {3'd0, 1'b0, 1'b0, CDEF, 1'b0},
          "R7", {ref_sel, ext_clk, bipolar, cfg_q, sda_oe}, {3'd0, 2'b00, CDEF, 1'b0});

    for (int k = 0; k < NV; k++) begin
      v = VEC[k];
      e_setup = 0; e_cfg = 0; n_setup = 0; n_cfg = 0; oe_bad = 1'b0;
      i2c_start();
      send_byte({v[25:19], v[18]}, ack);
      // R1 / R2 address acknowledge
      check(ack == v[26], v[26] ? "R1" : "R2", ack, v[26]);
      for (int j = 0; j < int'(v[17:16]); j++) begin
        logic [7:0] b;
        b = (j == 0) ? v[15:8] : v[7:0];
        send_byte(b, ack);
        // R6 data acknowledge (R2 when not addressed)
        check(ack == v[26], v[26] ? "R6" : "R2", ack, v[26]);
        if (v[26]) model_byte(b);
      end
      i2c_stop();
      wt(5);
      check_regs("R3 R4 R5");
      // R9 strobe counts
      check(n_setup == e_setup && n_cfg == e_cfg, "R9", n_setup * 16 + n_cfg, e_setup * 16 + e_cfg);
      // R10 no drive during data bits
      check(!oe_bad, "R10", oe_bad, 0);
    end

    // R6 three bytes in one transaction, last wins
    i2c_start();
    send_byte({DEV, 1'b0}, ack);
    send_byte(8'h0F, ack); model_byte(8'h0F);
    send_byte(8'hE2, ack); model_byte(8'hE2);
    send_byte(8'h1D, ack); model_byte(8'h1D);
    check(ack == 1'b1, "R6", ack, 1);
    i2c_stop(); wt(5);
    check_regs("R6");

    // R8 repeated START begins new address phase
    i2c_start();
    send_byte({DEV, 1'b0}, ack);
    send_byte(8'h21, ack); model_byte(8'h21);
    i2c_start();
    wt(5);
    check_regs("R8");
    send_byte({7'h36, 1'b0}, ack);
    check(ack == 1'b0, "R2", ack, 0);
    send_byte(8'h5A, ack);
    check(ack == 1'b0, "R2", ack, 0);
    i2c_start();
    send_byte({DEV, 1'b0}, ack);
    check(ack == 1'b1, "R8", ack, 1);
    send_byte(8'h3C, ack); model_byte(8'h3C);
    i2c_stop(); wt(5);
    check_regs("R8");

    // R8 bits after STOP without START are ignored
    send_byte({DEV, 1'b0}, ack);
    check(ack == 1'b0, "R8", ack, 0);
    send_byte(8'h44, ack);
    check(ack == 1'b0, "R8", ack, 0);
    i2c_stop(); wt(5);
    check_regs("R8");

    // R5 setup byte with bit 1 = 1 keeps cfg; bit 0 has no effect (R3)
    i2c_start();
    send_byte({DEV, 1'b0}, ack);
    send_byte(8'hB3, ack); model_byte(8'hB3);
    i2c_stop(); wt(5);
    check_regs("R5");
    check(cfg_q == 8'h3C, "R5", cfg_q, 8'h3C);

    // R7 reset mid-run restores defaults
    rst_n = 1'b0; wt(3); rst_n = 1'b1; wt(3);
    check({ref_sel, ext_clk, bipolar, cfg_q} == {3'd0, 2'b00, CDEF}, "R7",
          {ref_sel, ext_clk, bipolar, cfg_q}, {3'd0, 2'b00, CDEF});

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule